// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low address bits for a four-beat memory burst. When the surrounding logic accepts an address strobe, it pulses `load` and presents the two low address bits on `start_off`. The block takes those bits as the first offset of the burst. After that, each rising clock edge with the active-low `adv_n` held low moves the output to the next offset. While `adv_n` is high, the output keeps its value and the burst is suspended.

A static `mode` input picks the order. Linear order steps the offset as an increment modulo four. Interleaved order forms each offset as the start XOR the beat number. The block keeps the start value and a two-bit beat count internally. The offset is derived from these two values, so it wraps back to the start after the fourth beat. `last_beat` marks the fourth beat. A new `load` during a burst replaces the base and restarts the count, which abandons the old sequence.

Top module: `burst_seq`

## Requirements
- R1: In the cycle after a synchronous reset (`rst` high), `offset` is 00 and `last_beat` is 0.
- R2: In the cycle after a rising edge with `load` high, `offset` equals the `start_off` sampled at that edge and `last_beat` is 0, in either mode.
- R3: At an edge with `load` low and `adv_n` high, `offset` and `last_beat` keep their values.
- R4: With `mode` = 0 (linear), each edge with `load` low and `adv_n` low makes `offset` the previous offset plus one, modulo 4 (start 01 gives 01, 10, 11, 00).
- R5: With `mode` = 1 (interleaved), the n-th offset of a burst is start XOR n (start 10 gives 10, 11, 00, 01; start 11 gives 11, 10, 01, 00).
- R6: After four advances from a load, `offset` is back at the start value and the next sequence repeats the same order.
- R7: `load` takes priority over `adv_n` at the same edge. A load during a burst restarts the burst at beat 0 from the new start.
- R8: `last_beat` is 1 exactly when the beat count since the last load is 3, modulo 4. This is the fourth offset of the sequence.
- R9: `mode` = 0 selects the linear order and `mode` = 1 selects the interleaved order. The order applies to the offset immediately, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Accepted address strobe: load a new start offset |
| start_off | input | 2 | Low address bits captured on load |
| adv_n | input | 1 | Active-low advance to the next beat |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| offset | output | 2 | Current burst offset |
| last_beat | output | 1 | High on the fourth beat of the sequence |

## Verification
A wrong base register shows at `offset` in the cycle after a load. A wrong beat count can show the same cycle as the base, because the bench loads with the count at 0. It can also show only after the first advance, or only in one mode. The two orders agree on the first beat, and for starts 00 and 10 they also agree on the second. The bench therefore runs every start in both modes through a full wrap. A stale `last_beat` shows within four advances. A fault in load-versus-advance priority shows the cycle after a load that coincides with an advance.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
// Holds the burst base and the number of beats taken since the last load.
module burst_beat_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         adv_n,
  input  logic [W-1:0] start_in,
  output logic [W-1:0] base_q,
  output logic [W-1:0] beat_q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= start_in;
      beat_q <= '0;
    end else if (!adv_n) begin
      beat_q <= beat_q + ONE;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
// Maps base and beat number onto the offset for the selected order.
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] beat,
  input  logic         mode,
  output logic [W-1:0] offset
);
  logic [W-1:0] lin_off;
  logic [W-1:0] ilv_off;

  assign lin_off = base + beat;

  for (genvar i = 0; i < W; i++) begin : g_ilv
    assign ilv_off[i] = base[i] ^ beat[i];
  end

  always_comb begin
    unique case (order_e'(mode))
      ORD_INTERLEAVE: offset = ilv_off;
      default:        offset = lin_off;
    endcase
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] start_off,
  input  logic         adv_n,
  input  logic         mode,
  output logic [W-1:0] offset,
  output logic         last_beat
);
  logic [W-1:0] base_q;
  logic [W-1:0] beat_q;

  burst_beat_ctr #(.W(W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .adv_n    (adv_n),
    .start_in (start_off),
    .base_q   (base_q),
    .beat_q   (beat_q)
  );

  burst_order_map #(.W(W)) u_map (
    .base   (base_q),
    .beat   (beat_q),
    .mode   (mode),
    .offset (offset)
  );

  assign last_beat = &beat_q;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int W = 2
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic [W-1:0] start_off,
  input logic         adv_n,
  input logic         mode,
  input logic [W-1:0] offset,
  input logic         last_beat
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (offset == '0 && !last_beat));

  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (offset == $past(start_off) && !last_beat));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> (($stable(offset) || !$stable(mode)) && $stable(last_beat)));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n && !mode) |=> (mode || offset == W'($past(offset) + 1'b1)));

  // R8
  last_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (last_beat && !load && !adv_n) |=> !last_beat);
endmodule

bind burst_seq burst_seq_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .start_off (start_off),
  .adv_n     (adv_n),
  .mode      (mode),
  .offset    (offset),
  .last_beat (last_beat)
);

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [1:0] start_off = 2'b00;
  logic       adv_n = 1'b1;
  logic       mode = 1'b1;
  logic [1:0] offset;
  logic       last_beat;

  int n_run = 0;
  int n_fail = 0;
  logic [1:0] m_start = 2'b00;
  logic [1:0] m_beat = 2'b00;

  always #5 clk = ~clk;

  burst_seq u_dut (
    .clk(clk), .rst(rst), .load(load), .start_off(start_off),
    .adv_n(adv_n), .mode(mode), .offset(offset), .last_beat(last_beat)
  );

  function automatic logic [1:0] exp_off(logic [1:0] s, logic [1:0] n, logic m);
    return m ? (s ^ n) : 2'(s + n);
  endfunction

  task automatic check(string tag, logic [1:0] eo, logic el);
    n_run++;
    if (offset !== eo || last_beat !== el) begin
      n_fail++;
      $display("FAIL %s: offset=%b last=%b expected offset=%b last=%b",
               tag, offset, last_beat, eo, el);
    end
  endtask

  // drive inputs away from the edge, clock, update the model, then compare
  task automatic step(string tag, logic ld, logic [1:0] s, logic an, logic m);
    @(negedge clk);
    load = ld; start_off = s; adv_n = an; mode = m;
    @(posedge clk);
    #1;
    if (ld) begin m_start = s; m_beat = 2'b00; end
    else if (!an) m_beat = m_beat + 2'd1;
    check(tag, exp_off(m_start, m_beat, m), m_beat == 2'b11);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5eed_0042);
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset", 2'b00, 1'b0);
    @(negedge clk); rst = 1'b0;

    // R4 linear from 01, then wrap (R6), last flag (R8)
    step("R2 load lin", 1'b1, 2'b01, 1'b1, 1'b0);
    step("R4 lin b1", 1'b0, 2'b00, 1'b0, 1'b0);
    step("R4 lin b2", 1'b0, 2'b00, 1'b0, 1'b0);
    step("R8 lin b3", 1'b0, 2'b00, 1'b0, 1'b0);
    step("R6 lin wrap", 1'b0, 2'b00, 1'b0, 1'b0);
    // R3 hold for several cycles
    step("R3 hold", 1'b0, 2'b10, 1'b1, 1'b0);
    step("R3 hold", 1'b0, 2'b11, 1'b1, 1'b0);

    // R5 interleaved from 10 and from 11
    step("R2 load ilv", 1'b1, 2'b10, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step("R5 ilv 10", 1'b0, 2'b00, 1'b0, 1'b1);
    step("R2 load ilv", 1'b1, 2'b11, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step("R5 ilv 11", 1'b0, 2'b00, 1'b0, 1'b1);

    // R7 load with advance in same cycle, mid-burst
    step("R7 midload", 1'b0, 2'b00, 1'b0, 1'b1);
    step("R7 load+adv", 1'b1, 2'b01, 1'b0, 1'b1);
    step("R7 after", 1'b0, 2'b00, 1'b0, 1'b1);

    // R9 every start in both modes over a full wrap
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++) begin
        step("R9 load", 1'b1, 2'(s), 1'b1, 1'(m));
        for (int b = 0; b < 5; b++) step("R9 order", 1'b0, 2'b00, 1'b0, 1'(m));
      end

    // R3 R4 R5 R7 R8 constrained random: mode changes only with a load
    for (int i = 0; i < 400; i++) begin
      logic ld;
      logic mm;
      ld = ($urandom % 6) == 0;
      mm = ld ? 1'($urandom) : mode;
      step("R3/R4/R5/R7/R8 rand", ld, 2'($urandom), 1'($urandom % 3 == 0), mm);
    end

    // R1 reset mid-burst
    step("R8 pre", 1'b1, 2'b11, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    m_start = 2'b00; m_beat = 2'b00;
    check("R1 reset again", 2'b00, 1'b0);
    @(negedge clk); rst = 1'b0;

    summary();
  end
endmodule